// File: doc/BRIEF.md
# Page Write Staging and Commit Engine

This block sits behind the serial bus controller of a byte-addressed non-volatile memory. During a write transaction the controller first hands it a start address, then every data byte it has accepted. The engine parks those bytes in a one-row staging latch of 128 bytes. The row is fixed by the upper address bits at load time. The column pointer advances after each byte and wraps inside the row.

When the controller sees the stop in the slot right after a data-byte acknowledge, it pulses commit. The engine then holds a busy flag for a fixed, parameterised number of system clocks. During the final 128 cycles of that window it copies the staged bytes into a synchronous array, one column per cycle. Only columns that actually received a byte are written. A stop anywhere else arrives as an abort pulse, and the staged bytes are dropped without a write.

The engine also holds the address counter. It follows the loaded start address and, once a commit finishes, moves to the byte after the last one staged. A read port on the array lets the surrounding logic fetch bytes with one cycle of latency.

Top module: `page_commit_engine`

## Requirements
- R1: After reset every array byte reads 8'hFF, busy is low and the address counter is zero. Read data on rd_data_o matches the address presented on rd_addr_i one clock earlier.
- R2: Bytes staged after an address load are committed to consecutive addresses, starting at the loaded address.
- R3: Only the low 7 address bits (the column) advance per staged byte. Overflow wraps to column 0 of the same row, a later byte overwrites an earlier one at the same column, and the row (upper bits) never changes within a transaction.
- R4: Only columns that received a byte in the transaction are written. Every other byte of the row keeps its previous contents.
- R5: An abort pulse discards the staged bytes. Busy stays low, the array is unchanged, and a commit after the abort finds nothing to write.
- R6: A commit with no staged byte, or with wc_i high, leaves busy low and discards the staging. A byte presented while wc_i is high is not staged and does not advance the column.
- R7: An accepted commit raises busy on the next clock. Busy then stays high for exactly BUSY_CYCLES clocks, and every array write happens while busy is high.
- R8: An address load sets the address counter. When a commit completes, the counter becomes {row, column after the last staged byte}. An abort or a refused commit leaves it unchanged.
- R9: While busy is high, address loads, data bytes, commit and abort pulses are ignored. The busy window keeps its full length and the staging is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wc_i | input | 1 | Write inhibit; high blocks staging and commits |
| addr_load_i | input | 1 | Pulse: load start address and open a new transaction |
| addr_i | input | ADDR_W | Start address loaded by addr_load_i |
| byte_vld_i | input | 1 | Pulse: one accepted data byte |
| byte_i | input | 8 | Data byte qualified by byte_vld_i |
| commit_i | input | 1 | Pulse: stop seen right after a data-byte acknowledge |
| abort_i | input | 1 | Pulse: stop seen in any other slot |
| busy_o | output | 1 | Commit in progress |
| addr_o | output | ADDR_W | Address counter |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array read data, one clock after rd_addr_i |

## Verification
The bench builds the engine with ADDR_W = 10, which gives eight rows, and BUSY_CYCLES = 160. The small array can be swept in full after every transaction, so a stray write anywhere in it is caught, not only in the row under test. The short busy window keeps the exact busy-length count and the input disturbance during busy within a few hundred cycles. The 32 idle cycles before the flush still exercise the wait phase ahead of the array writes. Random transactions of up to 160 bytes start at random columns, so row wrap and overwrite occur often, mixed with aborts and write-inhibited commits.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int PAGE_BYTES = 128;
    localparam int COL_W      = $clog2(PAGE_BYTES);
    localparam int BYTE_W     = 8;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [COL_W-1:0]  col_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_FLUSH
    } seq_state_e;

    // column advance wraps inside the row by width
    function automatic col_t col_next(col_t c);
        return c + col_t'(1);
    endfunction
endpackage

// File: rtl/pgw_array.sv
module pgw_array #(
    parameter int ADDR_W = 10
) (
    input  logic                 clk,
    input  logic                 we_i,
    input  logic [ADDR_W-1:0]    waddr_i,
    input  pgw_pkg::byte_t       wdata_i,
    input  logic [ADDR_W-1:0]    raddr_i,
    output pgw_pkg::byte_t       rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    pgw_pkg::byte_t mem [DEPTH];
    pgw_pkg::byte_t rdata_q;

    // erased state at power-up
    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
    end

    always @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
        rdata_q <= mem[raddr_i];
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/pgw_stage.sv
module pgw_stage
    import pgw_pkg::*;
#(
    parameter int ROW_W = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    busy_i,
    input  logic                    load_i,
    input  logic [ROW_W+COL_W-1:0]  load_addr_i,
    input  logic                    take_i,
    input  byte_t                   byte_i,
    input  logic                    clear_i,
    input  col_t                    rd_idx_i,
    output byte_t                   rd_byte_o,
    output logic                    rd_valid_o,
    output logic                    any_o,
    output logic [ROW_W-1:0]        row_o,
    output col_t                    col_o
);
    logic [ROW_W-1:0]      row_q;
    col_t                  col_q;
    logic [PAGE_BYTES-1:0] mask_q;
    byte_t                 latch_q [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q  <= '0;
            col_q  <= '0;
            mask_q <= '0;
        end else if (load_i) begin
            row_q  <= load_addr_i[ROW_W+COL_W-1:COL_W];
            col_q  <= load_addr_i[COL_W-1:0];
            mask_q <= '0;
        end else if (clear_i) begin
            mask_q <= '0;
        end else if (take_i) begin
            mask_q[col_q] <= 1'b1;
            col_q         <= col_next(col_q);
        end
    end

    always_ff @(posedge clk) begin
        if (take_i && !load_i && !clear_i) latch_q[col_q] <= byte_i;
    end

    assign rd_byte_o  = latch_q[rd_idx_i];
    assign rd_valid_o = mask_q[rd_idx_i];
    assign any_o      = |mask_q;
    assign row_o      = row_q;
    assign col_o      = col_q;

    // R3: staging a byte never moves the row
    p_row_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (take_i && !load_i) |=> $stable(row_q));

    // R9: staging is frozen while a commit runs
    p_stage_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_i && $past(busy_i)) |-> ($stable(mask_q) && $stable(col_q)));
endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
    import pgw_pkg::*;
#(
    parameter int BUSY_CYCLES = 2_000_000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  commit_i,
    input  logic  wc_i,
    input  logic  any_i,
    output logic  start_o,
    output logic  refuse_o,
    output logic  busy_o,
    output logic  done_o,
    output logic  wr_en_o,
    output col_t  wr_idx_o
);
    localparam int WAIT_CYC = (BUSY_CYCLES > PAGE_BYTES) ? BUSY_CYCLES - PAGE_BYTES : 0;
    localparam int WAIT_W   = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

    seq_state_e        state_q;
    logic [WAIT_W-1:0] wait_q;
    col_t              idx_q;

    assign start_o  = commit_i && (state_q == SQ_IDLE) && any_i && !wc_i;
    assign refuse_o = commit_i && (state_q == SQ_IDLE) && !start_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            wait_q  <= '0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (start_o) begin
                        idx_q <= '0;
                        if (WAIT_CYC > 0) begin
                            state_q <= SQ_WAIT;
                            wait_q  <= WAIT_W'(WAIT_CYC - 1);
                        end else begin
                            state_q <= SQ_FLUSH;
                        end
                    end
                end
                SQ_WAIT: begin
                    if (wait_q == '0) state_q <= SQ_FLUSH;
                    else              wait_q  <= wait_q - WAIT_W'(1);
                end
                SQ_FLUSH: begin
                    if (idx_q == col_t'(PAGE_BYTES - 1)) state_q <= SQ_IDLE;
                    idx_q <= col_next(idx_q);
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy_o   = (state_q != SQ_IDLE);
    assign wr_en_o  = (state_q == SQ_FLUSH);
    assign done_o   = (state_q == SQ_FLUSH) && (idx_q == col_t'(PAGE_BYTES - 1));
    assign wr_idx_o = idx_q;

    // R7: busy follows an accepted commit by one clock
    p_busy_rise_r7: assert property (@(posedge clk) disable iff (rst)
        start_o |=> busy_o);

    // R7: busy drops with the final flush cycle
    p_busy_fall_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    // R6: empty or inhibited commit never raises busy
    p_refused_idle_r6: assert property (@(posedge clk) disable iff (rst)
        refuse_o |=> !busy_o);
endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine
    import pgw_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int BUSY_CYCLES = 2_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wc_i,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    input  logic              commit_i,
    input  logic              abort_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] addr_o,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);
    localparam int ROW_W = ADDR_W - COL_W;

    logic             busy, done, start, refuse, wr_en, any;
    col_t             wr_idx, col;
    logic [ROW_W-1:0] row;
    byte_t            st_byte;
    logic             st_valid;
    logic             load_ok, take_ok, clear;
    logic             mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [ADDR_W-1:0] ctr_q;

    assign load_ok = addr_load_i && !busy;
    assign take_ok = byte_vld_i && !busy && !wc_i;
    assign clear   = done || refuse || (abort_i && !busy);

    pgw_stage #(.ROW_W(ROW_W)) u_stage (
        .clk         (clk),
        .rst         (rst),
        .busy_i      (busy),
        .load_i      (load_ok),
        .load_addr_i (addr_i),
        .take_i      (take_ok),
        .byte_i      (byte_i),
        .clear_i     (clear),
        .rd_idx_i    (wr_idx),
        .rd_byte_o   (st_byte),
        .rd_valid_o  (st_valid),
        .any_o       (any),
        .row_o       (row),
        .col_o       (col)
    );

    pgw_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .commit_i (commit_i),
        .wc_i     (wc_i),
        .any_i    (any),
        .start_o  (start),
        .refuse_o (refuse),
        .busy_o   (busy),
        .done_o   (done),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx)
    );

    assign mem_we   = wr_en && st_valid;
    assign mem_addr = {row, wr_idx};

    pgw_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_addr),
        .wdata_i (st_byte),
        .raddr_i (rd_addr_i),
        .rdata_o (rd_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst)          ctr_q <= '0;
        else if (done)    ctr_q <= {row, col};
        else if (load_ok) ctr_q <= addr_i;
    end

    assign busy_o = busy;
    assign addr_o = ctr_q;

    // R7: array writes only inside the busy window
    p_write_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy_o);

    // R9: counter holds while the commit is still running
    p_ctr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done) |=> $stable(addr_o));
endmodule

// File: tb/page_commit_engine_test.sv
`timescale 1ns/1ps
module page_commit_engine_test;
    localparam int ADDR_W = 10;
    localparam int BUSY   = 160;
    localparam int PAGE   = 128;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wc_i = 1'b0, addr_load_i = 1'b0, byte_vld_i = 1'b0;
    logic              commit_i = 1'b0, abort_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0, rd_addr_i = '0;
    logic [7:0]        byte_i = '0;
    logic              busy_o;
    logic [ADDR_W-1:0] addr_o;
    logic [7:0]        rd_data_o;

    page_commit_engine #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst(rst), .wc_i(wc_i), .addr_load_i(addr_load_i), .addr_i(addr_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .commit_i(commit_i), .abort_i(abort_i),
        .busy_o(busy_o), .addr_o(addr_o), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;

    logic [7:0] ref_mem [DEPTH];
    logic [7:0] stg_data [PAGE];
    bit         stg_mask [PAGE];
    int         stg_row, stg_col, bctr;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        summary();
    end

    function automatic bit stg_any();
        for (int i = 0; i < PAGE; i++) if (stg_mask[i]) return 1;
        return 0;
    endfunction

    function automatic void stg_clear();
        for (int i = 0; i < PAGE; i++) stg_mask[i] = 0;
    endfunction

    task automatic do_load(int a);
        addr_i = ADDR_W'(a); addr_load_i = 1'b1;
        @(negedge clk);
        addr_load_i = 1'b0;
        stg_row = a / PAGE; stg_col = a % PAGE; bctr = a;
        stg_clear();
    endtask

    task automatic send_byte(logic [7:0] b, bit wc);
        byte_i = b; byte_vld_i = 1'b1; wc_i = wc;
        @(negedge clk);
        byte_vld_i = 1'b0; wc_i = 1'b0;
        if (!wc) begin
            stg_data[stg_col] = b; stg_mask[stg_col] = 1;
            stg_col = (stg_col + 1) % PAGE;
        end
    endtask

    task automatic commit_txn(bit wc, bit disturb, string req);
        bit expect_busy = stg_any() && !wc;
        int cnt = 0;
        wc_i = wc; commit_i = 1'b1;
        @(negedge clk);
        commit_i = 1'b0; wc_i = 1'b0;
        check(busy_o == expect_busy, expect_busy ? "R7 busy rise" : "R6 no busy",
              int'(busy_o), int'(expect_busy));
        while (busy_o && cnt < 1000) begin
            cnt++;
            if (disturb && cnt == 2) begin
                // R9: pulses during busy
                addr_i = '1; addr_load_i = 1'b1; byte_i = 8'hC3; byte_vld_i = 1'b1;
                abort_i = 1'b1; commit_i = 1'b1;
                @(negedge clk);
                addr_load_i = 1'b0; byte_vld_i = 1'b0; abort_i = 1'b0; commit_i = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        if (expect_busy) begin
            check(cnt == BUSY, "R7 busy length", cnt, BUSY);
            for (int i = 0; i < PAGE; i++)
                if (stg_mask[i]) ref_mem[stg_row * PAGE + i] = stg_data[i];
            bctr = stg_row * PAGE + stg_col;
        end
        stg_clear();
        check(addr_o == ADDR_W'(bctr), {"R8 counter ", req}, int'(addr_o), bctr);
    endtask

    task automatic abort_txn();
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        check(busy_o == 1'b0, "R5 abort no busy", int'(busy_o), 0);
        stg_clear();
        check(addr_o == ADDR_W'(bctr), "R8 counter after abort", int'(addr_o), bctr);
    endtask

    task automatic sweep(string req);
        int bad = 0;
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr_i = ADDR_W'(a);
            @(negedge clk);
            if (rd_data_o !== ref_mem[a]) begin
                if (bad < 4)
                    $display("FAIL %s addr %0h actual %0h expected %0h", req, a, rd_data_o, ref_mem[a]);
                bad++;
            end
        end
        checks++;
        if (bad != 0) errors++;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        stg_clear(); stg_row = 0; stg_col = 0; bctr = 0;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
        check(addr_o == '0, "R1 counter after reset", int'(addr_o), 0);
        sweep("R1 erased array");

        // R2: single byte
        do_load(12'h085);
        send_byte(8'h5A, 0);
        commit_txn(0, 0, "R2 single");
        sweep("R2 single byte");

        // R2: short run
        do_load(12'h0C0);
        for (int i = 0; i < 6; i++) send_byte(8'(8'h10 + i), 0);
        commit_txn(0, 0, "R2 run");
        sweep("R2 run");

        // R3: wrap inside row
        do_load(12'h17A);
        for (int i = 0; i < 10; i++) send_byte(8'(8'hA0 + i), 0);
        commit_txn(0, 0, "R3 wrap");
        check(addr_o == ADDR_W'(12'h104), "R3 wrapped counter", int'(addr_o), 12'h104);
        sweep("R3 wrap");

        // R3: overwrite after full wrap
        do_load(12'h200);
        for (int i = 0; i < 130; i++) send_byte(8'(i * 3 + 1), 0);
        commit_txn(0, 0, "R3 overwrite");
        sweep("R3 overwrite");

        // R4: sparse writes keep the rest of the row
        do_load(12'h2F0);
        for (int i = 0; i < 5; i++) send_byte(8'(8'h60 + i), 0);
        commit_txn(0, 0, "R4 first");
        do_load(12'h290);
        send_byte(8'h77, 0); send_byte(8'h88, 0);
        commit_txn(0, 0, "R4 second");
        sweep("R4 sparse");

        // R6: empty commit
        do_load(12'h010);
        commit_txn(0, 0, "R6 empty");

        // R6: inhibited bytes and inhibited commit
        do_load(12'h020);
        send_byte(8'h11, 1); send_byte(8'h22, 1);
        commit_txn(0, 0, "R6 inhibited bytes");
        do_load(12'h030);
        send_byte(8'h33, 0); send_byte(8'h44, 0);
        commit_txn(1, 0, "R6 inhibited commit");
        commit_txn(0, 0, "R6 discarded");
        sweep("R6 no write");

        // R5: abort
        do_load(12'h340);
        for (int i = 0; i < 4; i++) send_byte(8'(8'hE0 + i), 0);
        abort_txn();
        commit_txn(0, 0, "R5 after abort");
        sweep("R5 abort");

        // R9: inputs ignored while busy
        do_load(12'h105);
        send_byte(8'h01, 0); send_byte(8'h02, 0); send_byte(8'h03, 0);
        commit_txn(0, 1, "R9 disturb");
        check(addr_o == ADDR_W'(12'h108), "R9 counter", int'(addr_o), 12'h108);
        commit_txn(0, 0, "R9 nothing staged");
        sweep("R9 array");

        // random transactions
        for (int t = 0; t < 24; t++) begin
            int a  = int'($urandom % DEPTH);
            bit wc = ($urandom % 5) == 0;
            int n  = 1 + int'($urandom % 160);
            do_load(a);
            for (int i = 0; i < n; i++) send_byte(8'($urandom), (wc && (i % 2 == 0)));
            if (($urandom % 4) == 0) abort_txn();
            else commit_txn(wc, 0, "R2 random");
            if (t % 3 == 2) sweep("R3 R4 random");
        end
        sweep("R2 final");

        summary();
    end
endmodule